// File: doc/BRIEF.md
# Interrupt Recognition and Vectoring Unit

This unit sits at the instruction boundary of a small processor core and decides which interrupt, if any, the core takes next. It watches four sources: a non-maskable request line that counts only after a qualified rising edge, a level-sensitive maskable request line gated by an internal enable flag, a divide-overflow fault pulse, and a software-interrupt pulse that carries its own type code. A decoder-driven inhibit input holds off external requests at the boundary that follows a prefix or a segment-register load.

When an interrupt is chosen, the unit emits a one-cycle take strobe together with the 8-bit type code and the byte address of that type's entry in the vector table. For the maskable line, the unit first runs an acknowledge handshake with an external controller and latches the type code that the controller supplies. Stacking of the return state, decoding and the external controller are handled elsewhere.

Top module: `irq_vector_unit`

## Requirements
- R1: After reset, take and inta are 0, the enable flag (ie_flag) is 0, and no non-maskable request is pending.
- R2: A non-maskable request is latched only when nmi_in is sampled low, then high on two consecutive rising clock edges. A pulse that is high for only one sampled edge is ignored.
- R3: A latched non-maskable request is taken at the next boundary that is not inhibited, whatever ie_flag holds. It uses type 2, vector address 8, and no acknowledge cycle.
- R4: intr_in is honoured only when it is high and ie_flag is 1 at a boundary. Otherwise the boundary produces neither take nor inta.
- R5: An honoured intr_in raises inta in the cycle after the boundary and keeps it high until type_valid is sampled. In the next cycle, take pulses with take_type equal to the type_data that was sampled, and inta is 0.
- R6: When a non-maskable request is pending and intr_in is honoured at the same boundary, the non-maskable request is taken and inta stays 0.
- R7: A boundary with inhibit high takes neither the non-maskable request nor intr_in. A pending non-maskable request is kept and taken at the next uninhibited boundary.
- R8: div_fault at a boundary takes type 0, vector address 0. It wins over the software interrupt and over every external request.
- R9: swi_req at a boundary takes the type on swi_type. It wins over a pending non-maskable request, which stays latched.
- R10: Every take clears ie_flag. This clear wins over ie_set in the same cycle. Otherwise ie_set sets the flag and ie_clr clears it.
- R11: Taking the non-maskable request clears its latch. A new qualified edge that arrives while an acknowledge is outstanding is latched and taken at a later boundary.
- R12: vec_addr always equals take_type multiplied by four, as a 10-bit byte address.
- R13: take does not pulse in a cycle that follows neither a boundary nor an accepted type_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nmi_in | input | 1 | Non-maskable request line, edge qualified |
| intr_in | input | 1 | Maskable level request line |
| ie_set | input | 1 | Set interrupt-enable flag |
| ie_clr | input | 1 | Clear interrupt-enable flag |
| boundary | input | 1 | Instruction completes this cycle |
| inhibit | input | 1 | Completed instruction defers external recognition |
| div_fault | input | 1 | Divide overflow on the completed instruction |
| swi_req | input | 1 | Completed instruction is a software interrupt |
| swi_type | input | 8 | Type code carried by the software interrupt |
| inta | output | 1 | Acknowledge to the external controller |
| type_valid | input | 1 | Controller presents a type code |
| type_data | input | 8 | Type code from the controller |
| take | output | 1 | One-cycle strobe: interrupt taken |
| take_type | output | 8 | Type code of the taken interrupt |
| vec_addr | output | 10 | Vector table byte address |
| ie_flag | output | 1 | Current interrupt-enable flag |

## Verification
A lost or stale pending latch for the non-maskable request shows at the next uninhibited boundary. A lost request gives no take there. A stale one gives a second type-2 take where none is due. A wrong acknowledge state shows as inta that never rises or never falls, or as a take carrying a type other than the one sampled from type_data, one cycle after type_valid. A wrong enable flag shows at once on ie_flag and at the next boundary where intr_in is high.

// File: rtl/irq_vector_unit.sv
module irq_vector_unit #(
  parameter int TW = 8,
  parameter logic [TW-1:0] NMI_TYPE = TW'(2),
  parameter logic [TW-1:0] DIV_TYPE = TW'(0)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          nmi_in,
  input  logic          intr_in,
  input  logic          ie_set,
  input  logic          ie_clr,
  input  logic          boundary,
  input  logic          inhibit,
  input  logic          div_fault,
  input  logic          swi_req,
  input  logic [TW-1:0] swi_type,
  output logic          inta,
  input  logic          type_valid,
  input  logic [TW-1:0] type_data,
  output logic          take,
  output logic [TW-1:0] take_type,
  output logic [TW+1:0] vec_addr,
  output logic          ie_flag
);

  logic          nmi_d, nmi_dd, nmi_pend, ack_st, ie_q, take_q;
  logic [TW-1:0] type_q;

  wire nmi_qual  = nmi_in & nmi_d & ~nmi_dd;
  wire open_b    = boundary & ~ack_st;
  wire ext_ok    = open_b & ~div_fault & ~swi_req & ~inhibit;
  wire pick_div  = open_b & div_fault;
  wire pick_swi  = open_b & ~div_fault & swi_req;
  wire pick_nmi  = ext_ok & nmi_pend;
  wire pick_intr = ext_ok & ~nmi_pend & intr_in & ie_q;
  wire ack_done  = ack_st & type_valid;
  wire fire      = pick_div | pick_swi | pick_nmi | ack_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nmi_d    <= 1'b0;
      nmi_dd   <= 1'b0;
      nmi_pend <= 1'b0;
      ack_st   <= 1'b0;
      ie_q     <= 1'b0;
      take_q   <= 1'b0;
      type_q   <= '0;
    end else begin
      nmi_d  <= nmi_in;
      nmi_dd <= nmi_d;
      if (nmi_qual)      nmi_pend <= 1'b1;
      else if (pick_nmi) nmi_pend <= 1'b0;
      if (pick_intr)     ack_st <= 1'b1;
      else if (ack_done) ack_st <= 1'b0;
      take_q <= fire;
      if (fire)
        type_q <= pick_div ? DIV_TYPE :
                  pick_swi ? swi_type :
                  pick_nmi ? NMI_TYPE : type_data;
      if (fire)        ie_q <= 1'b0;
      else if (ie_clr) ie_q <= 1'b0;
      else if (ie_set) ie_q <= 1'b1;
    end
  end

  assign inta      = ack_st;
  assign take      = take_q;
  assign take_type = type_q;
  assign vec_addr  = {type_q, 2'b00};
  assign ie_flag   = ie_q;

endmodule

// File: rtl/irq_vector_checker.sv
module irq_vector_checker #(
  parameter int TW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          boundary,
  input logic          inhibit,
  input logic          div_fault,
  input logic          swi_req,
  input logic [TW-1:0] swi_type,
  input logic          inta,
  input logic          type_valid,
  input logic [TW-1:0] type_data,
  input logic          take,
  input logic [TW-1:0] take_type,
  input logic          ie_flag
);

  AST_IE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> !ie_flag); // R10

  AST_INTA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    inta && !type_valid |=> inta); // R5

  AST_INTA_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    inta && type_valid |=> take && !inta && take_type == $past(type_data)); // R5

  AST_DIV_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    boundary && div_fault && !inta |=> take && take_type == '0); // R8

  AST_SWI_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
    boundary && swi_req && !div_fault && !inta |=> take && take_type == $past(swi_type)); // R9

  AST_INHIBIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    boundary && inhibit && !div_fault && !swi_req && !inta |=> !take && !inta); // R7

  AST_NO_SPONT: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary && !(inta && type_valid) |=> !take); // R13

endmodule

bind irq_vector_unit irq_vector_checker #(.TW(TW)) u_chk (.*);

// File: tb/sim_irq_vector_unit.sv
module sim_irq_vector_unit;
  logic clk = 1'b0, rst_n = 1'b0;
  logic nmi_in = 0, intr_in = 0, ie_set = 0, ie_clr = 0, boundary = 0, inhibit = 0;
  logic div_fault = 0, swi_req = 0, type_valid = 0;
  logic [7:0] swi_type = 8'h00, type_data = 8'h00;
  logic inta, take, ie_flag;
  logic [7:0] take_type;
  logic [9:0] vec_addr;
  int checks = 0, errors = 0;
  logic tk, ia;
  logic [7:0] ty;
  logic [9:0] va;

  always #4 clk = ~clk;

  irq_vector_unit u0 (.*);

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic bnd(input logic inh, input logic dv, input logic sw, input logic [7:0] st);
    @(negedge clk);
    boundary = 1; inhibit = inh; div_fault = dv; swi_req = sw; swi_type = st;
    @(posedge clk); #1;
    tk = take; ty = take_type; va = vec_addr; ia = inta;
    @(negedge clk);
    boundary = 0; inhibit = 0; div_fault = 0; swi_req = 0;
  endtask

  task automatic nmi_pulse(input int n);
    @(negedge clk); nmi_in = 1;
    repeat (n) @(negedge clk);
    nmi_in = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic enable_ie();
    @(negedge clk); ie_set = 1;
    @(negedge clk); ie_set = 0;
  endtask

  task automatic t_reset();
    chk("R1 take", take, 0);
    chk("R1 inta", inta, 0);
    chk("R1 ie_flag", ie_flag, 0);
    intr_in = 1;
    bnd(0, 0, 0, 0);
    chk("R4 no take with ie=0", tk, 0);
    chk("R4 no inta with ie=0", ia, 0);
    intr_in = 0;
    bnd(0, 0, 0, 0);
    chk("R1 nothing pending", tk, 0);
  endtask

  task automatic t_nmi();
    nmi_pulse(1);
    bnd(0, 0, 0, 0);
    chk("R2 short pulse ignored", tk, 0);
    nmi_pulse(3);
    bnd(0, 0, 0, 0);
    chk("R3 nmi taken with ie=0", tk, 1);
    chk("R3 nmi type", ty, 2);
    chk("R3 nmi vec", va, 8);
    chk("R3 no ack for nmi", ia, 0);
    bnd(0, 0, 0, 0);
    chk("R11 latch cleared", tk, 0);
  endtask

  task automatic t_intr();
    enable_ie();
    intr_in = 1;
    bnd(0, 0, 0, 0);
    chk("R5 inta raised", ia, 1);
    chk("R5 no take yet", tk, 0);
    repeat (3) @(negedge clk);
    chk("R5 inta held", inta, 1);
    type_valid = 1; type_data = 8'h41;
    @(posedge clk); #1;
    chk("R5 take", take, 1);
    chk("R5 type", take_type, 8'h41);
    chk("R12 vec", vec_addr, 10'h104);
    chk("R5 inta dropped", inta, 0);
    chk("R10 ie cleared", ie_flag, 0);
    @(negedge clk); type_valid = 0;
    @(posedge clk); #1;
    chk("R13 take one cycle", take, 0);
    bnd(0, 0, 0, 0);
    chk("R4 masked after take", ia, 0);
    intr_in = 0;
  endtask

  task automatic t_priority();
    enable_ie();
    intr_in = 1;
    nmi_pulse(2);
    bnd(0, 0, 0, 0);
    chk("R6 nmi over intr", ty, 2);
    chk("R6 take", tk, 1);
    chk("R6 no inta", ia, 0);
    intr_in = 0;
  endtask

  task automatic t_inhibit();
    nmi_pulse(2);
    bnd(1, 0, 0, 0);
    chk("R7 inhibited", tk, 0);
    bnd(0, 0, 0, 0);
    chk("R7 taken next", tk, 1);
    chk("R7 type", ty, 2);
  endtask

  task automatic t_internal();
    nmi_pulse(2);
    bnd(0, 1, 1, 8'h21);
    chk("R8 div taken", tk, 1);
    chk("R8 div type", ty, 0);
    chk("R8 div vec", va, 0);
    bnd(0, 0, 1, 8'h21);
    chk("R9 swi taken", tk, 1);
    chk("R9 swi type", ty, 8'h21);
    chk("R12 swi vec", va, 10'h084);
    bnd(0, 0, 0, 0);
    chk("R9 nmi still latched", ty, 2);
    chk("R9 nmi take", tk, 1);
  endtask

  task automatic t_ie_race();
    enable_ie();
    chk("R10 ie set", ie_flag, 1);
    @(negedge clk);
    ie_set = 1; boundary = 1; swi_req = 1; swi_type = 8'hFF;
    @(posedge clk); #1;
    chk("R10 clear wins", ie_flag, 0);
    chk("R12 max vec", vec_addr, 10'h3FC);
    @(negedge clk);
    ie_set = 0; boundary = 0; swi_req = 0;
    enable_ie();
    @(negedge clk); ie_clr = 1;
    @(negedge clk); ie_clr = 0;
    chk("R10 ie_clr", ie_flag, 0);
  endtask

  task automatic t_nmi_in_ack();
    enable_ie();
    intr_in = 1;
    bnd(0, 0, 0, 0);
    chk("R11 in ack", ia, 1);
    intr_in = 0;
    nmi_pulse(2);
    @(negedge clk); type_valid = 1; type_data = 8'h08;
    @(posedge clk); #1;
    chk("R11 intr taken", take_type, 8'h08);
    @(negedge clk); type_valid = 0;
    bnd(0, 0, 0, 0);
    chk("R11 nmi kept", tk, 1);
    chk("R11 nmi type", ty, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    t_reset();
    t_nmi();
    t_intr();
    t_priority();
    t_inhibit();
    t_internal();
    t_ie_race();
    t_nmi_in_ack();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 20000);
    checks++; errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule